// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block runs the external side of a parallel memory port in which address and data share one sixteen-line bus. An internal client presents a request that carries a 24-bit address, 16-bit write data, a direction flag and a device-width flag. The block then sequences one external bus cycle. First comes an address phase, in which the latch-enable strobe is high. Then comes a data phase, in which the active-low read or write strobe is held for a programmable number of cycles. Tristate control is given separately for each byte lane, so that a pad ring or a bench can model the shared pins.

With a 16-bit device, the single address phase carries address bits 15:0 and the data phase moves a full 16-bit word. With an 8-bit device, the address phase carries address bits 23:8. During the data phase, address bits 7:0 stay on the low byte lane and the data byte travels on the high lane. Read data is captured at the clock edge that ends the strobe. It is then returned with a one-cycle valid pulse.

The controller has three states. `ST_IDLE` moves to `ST_ADDR` when a request is accepted. `ST_ADDR` always moves to `ST_STROBE` after one cycle. `ST_STROBE` moves back to `ST_IDLE` when the wait counter reaches zero, and otherwise stays put.

Top module: `mux_ad_port`

## Requirements
- R1: After reset `busy`, `ale` and `rd_valid` are 0, `rd_n` and `wr_n` are 1 and `ad_oe` is 2'b00.
- R2: A request is accepted on a rising edge where `req_valid` is 1 and `busy` is 0. `busy` is 1 from the next cycle until the strobe ends. A `req_valid` that is seen while `busy` is 1 starts no bus cycle.
- R3: In the cycle after acceptance, `ale` is 1 for exactly one cycle and `ad_oe` is 2'b11. `ad_out` carries address bits 15:0 when `req_wide`=1, and address bits 23:8 when `req_wide`=0.
- R4: The strobe (`wr_n` for `req_write`=1, `rd_n` otherwise) goes low in the cycle after the `ale` cycle. It stays low for `wait_cfg`+1 consecutive cycles, and `wait_cfg` is sampled at acceptance. Only one strobe is ever low.
- R5: In a 16-bit write, `ad_out` equals the write data and `ad_oe` is 2'b11 in every strobe cycle.
- R6: In an 8-bit write, `ad_out` is {write data bits 7:0, address bits 7:0} and `ad_oe` is 2'b11 in every strobe cycle.
- R7: In a 16-bit read, `ad_oe` is 2'b00 during the strobe. `rd_data` equals `ad_in` as it was in the last strobe cycle, and `rd_valid` is 1 for exactly the one cycle after the strobe.
- R8: In an 8-bit read, `ad_oe` is 2'b01 and `ad_out[7:0]` holds address bits 7:0 during the strobe. `rd_data` is {8'h00, `ad_in[15:8]` from the last strobe cycle}.
- R9: `busy` falls in the cycle after the last strobe cycle. A request that is presented in that same cycle is accepted, so that bus cycles can run back to back.
- R10: Whenever `busy` is 0, `ad_oe` is 2'b00, `ale` is 0 and both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| req_addr | input | 24 | Request address |
| req_wdata | input | 16 | Write data (8-bit device uses bits 7:0) |
| wait_cfg | input | 4 | Strobe length minus one |
| busy | output | 1 | Bus cycle in progress |
| rd_valid | output | 1 | One-cycle read data valid |
| rd_data | output | 16 | Captured read data |
| ad_out | output | 16 | Value driven onto the shared bus |
| ad_oe | output | 2 | Output enable per byte lane, bit 1 = upper |
| ad_in | input | 16 | Value sampled from the shared bus |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The completion of a read and the acceptance of the next request can fall in the same cycle. In that cycle `rd_valid` pulses and `busy` has just fallen. The bench provokes this by issuing a new request as soon as it sees `busy` low after a read. The scoreboard then requires both the correct read word in that cycle and an `ale` cycle for the new request in the very next cycle. The modelled device also changes `ad_in` in every strobe cycle, so that a capture one cycle early or late shows up as a wrong value.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ADDR   = 2'd1,
        ST_STROBE = 2'd2
    } pp_state_e;

    localparam logic [1:0] LANES_OFF  = 2'b00;
    localparam logic [1:0] LANE_LOW   = 2'b01;
    localparam logic [1:0] LANES_BOTH = 2'b11;

endpackage

// File: rtl/pp_wait_count.sv
module pp_wait_count #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/pp_ad_drive.sv
module pp_ad_drive #(
    parameter int AD_W = 16
) (
    input  logic                       drive_addr,
    input  logic                       drive_data,
    input  logic                       write,
    input  logic                       wide,
    input  logic [AD_W+AD_W/2-1:0]     addr,
    input  logic [AD_W-1:0]            wdata,
    output logic [AD_W-1:0]            ad_out,
    output logic [1:0]                 ad_oe
);
    import pp_pkg::*;

    localparam int BYTE_W = AD_W / 2;
    localparam int ADDR_W = AD_W + BYTE_W;

    always_comb begin
        ad_out = '0;
        ad_oe  = LANES_OFF;
        if (drive_addr) begin
            ad_oe  = LANES_BOTH;
            ad_out = wide ? addr[AD_W-1:0] : addr[ADDR_W-1:BYTE_W];
        end else if (drive_data) begin
            if (wide) begin
                if (write) begin
                    ad_oe  = LANES_BOTH;
                    ad_out = wdata;
                end
            end else begin
                ad_out[BYTE_W-1:0] = addr[BYTE_W-1:0];
                if (write) begin
                    ad_oe  = LANES_BOTH;
                    ad_out[AD_W-1:BYTE_W] = wdata[BYTE_W-1:0];
                end else begin
                    ad_oe  = LANE_LOW;
                end
            end
        end
    end

endmodule

// File: rtl/pp_rd_capture.sv
module pp_rd_capture #(
    parameter int AD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            capture,
    input  logic            wide,
    input  logic [AD_W-1:0] ad_in,
    output logic [AD_W-1:0] rd_data,
    output logic            rd_valid
);

    localparam int BYTE_W = AD_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= wide ? ad_in
                                : {{BYTE_W{1'b0}}, ad_in[AD_W-1:BYTE_W]};
            end
        end
    end

endmodule

// File: rtl/mux_ad_port.sv
module mux_ad_port #(
    parameter int AD_W   = 16,
    parameter int WAIT_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic                   req_wide,
    input  logic [AD_W+AD_W/2-1:0] req_addr,
    input  logic [AD_W-1:0]        req_wdata,
    input  logic [WAIT_W-1:0]      wait_cfg,
    output logic                   busy,
    output logic                   rd_valid,
    output logic [AD_W-1:0]        rd_data,
    output logic [AD_W-1:0]        ad_out,
    output logic [1:0]             ad_oe,
    input  logic [AD_W-1:0]        ad_in,
    output logic                   ale,
    output logic                   rd_n,
    output logic                   wr_n
);
    import pp_pkg::*;

    localparam int ADDR_W = AD_W + AD_W / 2;

    pp_state_e          state_q, state_d;
    logic               write_q, wide_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [AD_W-1:0]    wdata_q;
    logic               accept, cnt_zero, in_strobe, last_strobe;

    assign accept      = req_valid && (state_q == ST_IDLE);
    assign in_strobe   = (state_q == ST_STROBE);
    assign last_strobe = in_strobe && cnt_zero;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_ADDR;
            ST_ADDR:                 state_d = ST_STROBE;
            ST_STROBE: if (cnt_zero) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            write_q <= 1'b0;
            wide_q  <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                write_q <= req_write;
                wide_q  <= req_wide;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

    // strobe and status outputs
    always_comb begin
        busy = 1'b1;
        ale  = 1'b0;
        rd_n = 1'b1;
        wr_n = 1'b1;
        unique case (state_q)
            ST_IDLE:   busy = 1'b0;
            ST_ADDR:   ale  = 1'b1;
            ST_STROBE: begin
                rd_n = write_q;
                wr_n = !write_q;
            end
            default:   busy = 1'b0;
        endcase
    end

    pp_wait_count #(.W(WAIT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (wait_cfg),
        .dec      (in_strobe),
        .zero     (cnt_zero)
    );

    pp_ad_drive #(.AD_W(AD_W)) u_drive (
        .drive_addr (state_q == ST_ADDR),
        .drive_data (in_strobe),
        .write      (write_q),
        .wide       (wide_q),
        .addr       (addr_q),
        .wdata      (wdata_q),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe)
    );

    pp_rd_capture #(.AD_W(AD_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (last_strobe && !write_q),
        .wide     (wide_q),
        .ad_in    (ad_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/pp_port_checker.sv
module pp_port_checker #(
    parameter int WAIT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [WAIT_W-1:0] wait_cfg,
    input logic              busy,
    input logic              rd_valid,
    input logic [1:0]        ad_oe,
    input logic              ale,
    input logic              rd_n,
    input logic              wr_n
);

    logic [WAIT_W:0] low_cnt, exp_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            exp_len <= '0;
        end else begin
            if (req_valid && !busy) exp_len <= {1'b0, wait_cfg} + 1'b1;
            if (!rd_n || !wr_n) low_cnt <= low_cnt + 1'b1;
            else                low_cnt <= '0;
        end
    end

    p_ale_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> (ale && ad_oe == 2'b11));
    p_ale_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    p_strobe_follows_ale_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!rd_n || !wr_n));
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rd_n) || $rose(wr_n)) |-> (low_cnt == exp_len));
    p_busy_in_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n || ale) |-> busy);
    p_write_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe == 2'b11));
    p_read_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe[1]);
    p_rdvalid_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(!rd_n) && rd_n));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ad_oe == 2'b00 && !ale && rd_n && wr_n));

endmodule

bind mux_ad_port pp_port_checker #(.WAIT_W(WAIT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .wait_cfg  (wait_cfg),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .ad_oe     (ad_oe),
    .ale       (ale),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/mux_ad_port_tb_top.sv
module mux_ad_port_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [3:0]  wait_cfg = '0;
    logic        busy, rd_valid, ale, rd_n, wr_n;
    logic [15:0] rd_data, ad_out;
    logic [1:0]  ad_oe;
    logic [15:0] ad_in = 16'hDEAD;
    logic [15:0] dev_base = '0;

    int checks = 0, errors = 0;
    bit finished = 0;

    typedef struct {
        bit          wr;
        logic [15:0] addr_word;
        logic [15:0] data_word;
        logic [15:0] data_mask;
        logic [1:0]  oe;
        int          len;
        logic [15:0] rd_exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_ad_port dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .wait_cfg(wait_cfg), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Driver: issue one request and push the expected bus behaviour
    task automatic issue(input bit wr, input bit wide, input logic [23:0] addr,
                         input logic [15:0] wd, input logic [3:0] wc,
                         input logic [15:0] base, input string tag);
        item_t it;
        logic [7:0] last;
        logic [15:0] v;
        @(negedge clk);
        while (busy) @(negedge clk);
        dev_base  = base;
        req_valid = 1'b1; req_write = wr; req_wide = wide;
        req_addr  = addr; req_wdata = wd; wait_cfg = wc;
        last = 8'(wc);
        v = base ^ {last, last};
        it.wr = wr; it.len = int'(wc) + 1; it.tag = tag;
        it.addr_word = wide ? addr[15:0] : addr[23:8];
        if (wr) begin
            it.oe = 2'b11; it.data_mask = 16'hFFFF;
            it.data_word = wide ? wd : {wd[7:0], addr[7:0]};
            it.rd_exp = '0;
        end else if (wide) begin
            it.oe = 2'b00; it.data_mask = 16'h0000; it.data_word = '0;
            it.rd_exp = v;
        end else begin
            it.oe = 2'b01; it.data_mask = 16'h00FF; it.data_word = {8'h00, addr[7:0]};
            it.rd_exp = {8'h00, v[15:8]};
        end
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        wait_cfg  = ~wc;        // R4: must not affect the cycle already accepted
    endtask

    // Device model: read data changes in every strobe cycle
    initial begin
        int k;
        k = 0;
        forever begin
            @(negedge clk);
            if (!rd_n) begin
                ad_in = dev_base ^ {8'(k), 8'(k)};
                k++;
            end else begin
                k = 0;
                ad_in = 16'hDEAD;
            end
        end
    end

    // Monitor / scoreboard
    initial begin
        item_t it;
        int n;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (ale) begin
                if (exp_q.size() == 0) begin
                    check(0, "R2 unexpected bus cycle", 32'(ad_out), 0);
                    continue;
                end
                it = exp_q.pop_front();
                check(ad_out == it.addr_word, {"R3 address word ", it.tag}, 32'(ad_out), 32'(it.addr_word));
                check(ad_oe == 2'b11, {"R3 address oe ", it.tag}, 32'(ad_oe), 3);
                check(busy, {"R2 busy in ale ", it.tag}, 32'(busy), 1);
                n = 0;
                @(negedge clk);
                while (!rd_n || !wr_n) begin
                    check(it.wr ? (!wr_n && rd_n) : (!rd_n && wr_n),
                          {"R4 strobe select ", it.tag}, {30'b0, rd_n, wr_n}, it.wr ? 32'd2 : 32'd1);
                    check(ad_oe == it.oe, {"R5 R6 R8 data oe ", it.tag}, 32'(ad_oe), 32'(it.oe));
                    check((ad_out & it.data_mask) == it.data_word,
                          {"R5 R6 R8 data word ", it.tag}, 32'(ad_out & it.data_mask), 32'(it.data_word));
                    check(busy, {"R2 busy in strobe ", it.tag}, 32'(busy), 1);
                    n++;
                    if (n > 20) break;
                    @(negedge clk);
                end
                check(n == it.len, {"R4 strobe length ", it.tag}, 32'(n), 32'(it.len));
                check(!busy, {"R9 busy falls ", it.tag}, 32'(busy), 0);
                check(rd_valid == !it.wr, {"R7 rd_valid pulse ", it.tag}, 32'(rd_valid), 32'(!it.wr));
                if (!it.wr)
                    check(rd_data == it.rd_exp, {"R7 R8 read data ", it.tag}, 32'(rd_data), 32'(it.rd_exp));
            end else if (!busy) begin
                check(ad_oe == 2'b00 && rd_n && wr_n && !rd_valid, "R10 idle quiet",
                      {28'b0, ad_oe, rd_n, wr_n}, 32'h3);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !ale && rd_n && wr_n && ad_oe == 2'b00 && !rd_valid,
              "R1 reset state", {26'b0, busy, ale, rd_n, wr_n, ad_oe}, 32'h0C);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        issue(1, 1, 24'h00_1234, 16'hBEEF, 4'd0, 16'h0, "w16");      // R5
        issue(1, 0, 24'hAB_CD_EF, 16'h0055, 4'd3, 16'h0, "w8");      // R6
        issue(0, 1, 24'h00_4321, 16'h0, 4'd2, 16'hA5C3, "r16");      // R7
        issue(0, 0, 24'h12_3456, 16'h0, 4'd15, 16'h3C96, "r8");      // R8
        // R9: back-to-back, second request in the rd_valid cycle
        issue(0, 0, 24'h77_8899, 16'h0, 4'd1, 16'h1F2E, "b2b_r8");
        issue(1, 1, 24'h00_FACE, 16'h1357, 4'd4, 16'h0, "b2b_w16");
        issue(0, 1, 24'h00_0F0F, 16'h0, 4'd0, 16'h8421, "b2b_r16a");
        issue(0, 1, 24'h00_F0F0, 16'h0, 4'd1, 16'h6B5A, "b2b_r16b");

        // R2: a request presented while busy is ignored
        issue(1, 0, 24'h55_66_77, 16'h00AA, 4'd5, 16'h0, "w8_busy");
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'hFF_FFFF; req_write = 1'b0;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);

        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, "R2 all bus cycles seen", 32'(exp_q.size()), 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule